// File: doc/BRIEF.md
# NAND Asynchronous Bus Controller

This block connects a simple single-request host port to an 8-bit raw NAND device over an asynchronous strobed bus. The host issues one access per request pulse. The access carries a byte address, a direction, a size and write data. Two fixed address bits choose what the byte cycle means on the bus. One bit marks a command byte and raises CLE. The other marks an address byte and raises ALE. A third address bit steers the access to a second device enable. Host accesses of 32 or 16 bits become a burst of byte cycles on the device bus, one lane at a time.

Every byte cycle has three phases: a setup phase, a strobe phase and a hold phase. Their lengths come from a packed timing word, with separate fields for reads and writes. When the bus changes direction between accesses, a turnaround gap is inserted first. The shared, wired-AND ready/busy line of the attached devices is resynchronised and presented as a ready flag. A mode-enable input lets the host retire requests without touching the bus.

Top module: `nand_async_ctrl`

## Requirements
- R1: Byte address bit 4 set makes the access a command access: CLE is high during every setup, strobe and hold cycle of that access. Bit 3 set with bit 4 clear makes it an address access, with ALE high over the same cycles. When both bits are set, only CLE rises. Outside those phases ALE and CLE are low.
- R2: `req_size` 0 gives one byte cycle, 1 gives two and 2 or 3 gives four. Byte cycle k carries lane k, which is bits 8k+7 to 8k of the host word, with lane 0 first. Address bits 1:0 have no effect on any bus output.
- R3: The timing word is laid out as follows. Write setup is at bits 29:26, write strobe at 25:20, write hold at 19:17, read setup at 16:13, read strobe at 12:7, read hold at 6:4 and turnaround at 3:2. A field value N gives N+1 clock cycles in its phase. The word is sampled when a request is accepted.
- R4: Each byte cycle runs its setup cycles, then its strobe cycles, then its hold cycles. The write strobe (`nand_we_n`) or the read strobe (`nand_re_n`) is low only in the strobe phase, and never both at once. A strobe only falls after the device enable has been low for at least one cycle.
- R5: The selected device enable stays low without a gap from the first setup cycle of an access to the last hold cycle of its last byte. `req_ack` is high for exactly one cycle, in the cycle after that last hold cycle, and the enables are high in that cycle.
- R6: A turnaround gap is placed ahead of the first setup cycle when an enabled access differs in direction from the previous enabled access. The gap lasts turnaround+1 cycles, with all enables and strobes inactive. No gap is placed after reset or between accesses of the same direction.
- R7: Read data is sampled from `nand_dq_i` in the last strobe cycle of each byte cycle and placed in lane k of `req_rdata`. Lanes that are not transferred read as 0. `req_rdata` holds its value until the next request is accepted.
- R8: Address bit 12 clear selects `nand_ce_n[0]` and set selects `nand_ce_n[1]`. At most one enable is ever low.
- R9: While `nand_en` is low, a request is acknowledged in the next cycle with no bus activity and `req_rdata` reads 0. Such a request does not change the direction history used by R6.
- R10: `ready` equals `wait_in` delayed by two clock edges, through two flops that reset to 0 (busy).
- R11: During every phase of a write byte cycle, `nand_dq_oe` is high and `nand_dq_o` carries that lane's byte. At all other times `nand_dq_oe` is low and `nand_dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nand_en | input | 1 | NAND mode enable for this chip-select |
| cfg_timing | input | 32 | Packed phase timing word |
| req_valid | input | 1 | One-cycle request pulse, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| req_addr | input | 16 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Assembled read data |
| wait_in | input | 1 | Wired-AND ready/busy line, 1 = ready |
| ready | output | 1 | Synchronised ready flag |
| nand_ce_n | output | 2 | Active-low device enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_dq_o | output | 8 | Data to device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data from device |

## Verification
The properties assume that the host pulses `req_valid` for a single cycle and only while no access is in flight. They also assume that `cfg_timing` and `nand_en` do not change in the cycle of acceptance. The synchroniser check assumes `wait_in` is a level that the bench drives away from the clock edge. The stimulus issues each request as one pulse and waits until its full expected cycle schedule has drained before the next. It changes the timing word and the enable only between accesses and toggles the ready line on falling edges.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;

    localparam int HOST_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = HOST_W / LANE_W;
    localparam int LANE_IW = $clog2(LANES);
    localparam int CNT_W   = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } bus_phase_e;

    typedef struct packed {
        logic [3:0] wr_setup;
        logic [5:0] wr_strobe;
        logic [2:0] wr_hold;
        logic [3:0] rd_setup;
        logic [5:0] rd_strobe;
        logic [2:0] rd_hold;
        logic [1:0] turn;
    } bus_timing_t;

    function automatic bus_timing_t decode_timing(input logic [31:0] w);
        bus_timing_t t;
        t.wr_setup  = w[29:26];
        t.wr_strobe = w[25:20];
        t.wr_hold   = w[19:17];
        t.rd_setup  = w[16:13];
        t.rd_strobe = w[12:7];
        t.rd_hold   = w[6:4];
        t.turn      = w[3:2];
        return t;
    endfunction

    function automatic logic [LANE_IW-1:0] last_lane(input logic [1:0] sz);
        case (sz)
            2'd0:    return LANE_IW'(0);
            2'd1:    return LANE_IW'(1);
            default: return LANE_IW'(LANES - 1);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(input bus_timing_t t,
                                                   input bus_phase_e ph,
                                                   input logic wr);
        case (ph)
            PH_TURN:   return {4'b0, t.turn};
            PH_SETUP:  return wr ? {2'b0, t.wr_setup} : {2'b0, t.rd_setup};
            PH_STROBE: return wr ? t.wr_strobe : t.rd_strobe;
            PH_HOLD:   return wr ? {3'b0, t.wr_hold} : {3'b0, t.rd_hold};
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/nand_ready_sync.sv
module nand_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[STAGES-2:0], async_in};
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_byte_lanes.sv
module nand_byte_lanes #(
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int LANE_IW = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [LANE_IW-1:0]        lane_idx,
    input  logic [LANE_W-1:0]         dq_in,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANE_W-1:0]         wr_byte,
    output logic [LANES*LANE_W-1:0]   rdata
);
    always_comb begin
        wr_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_idx == LANE_IW'(i)) wr_byte = wdata[i*LANE_W +: LANE_W];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (rst || clear)                               rd_q <= '0;
            else if (capture && lane_idx == LANE_IW'(g))    rd_q <= dq_in;
        end
        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/nand_async_ctrl.sv
module nand_async_ctrl
    import nand_bus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ALE_BIT   = 3,
    parameter int CLE_BIT   = 4,
    parameter int CHIP2_BIT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nand_en,
    input  logic [31:0]       cfg_timing,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HOST_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [HOST_W-1:0] req_rdata,
    input  logic              wait_in,
    output logic              ready,
    output logic [1:0]        nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_ale,
    output logic              nand_cle,
    output logic [LANE_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [LANE_W-1:0] nand_dq_i
);
    bus_phase_e         phase_q, phase_d;
    bus_timing_t        tim_q, cfg_now;
    logic               wr_q, ale_q, cle_q, chip2_q;
    logic [HOST_W-1:0]  wdata_q;
    logic [LANE_IW-1:0] idx_q, last_q;
    logic               hist_v_q, hist_wr_q;

    logic               tmr_load, tmr_expired;
    logic [CNT_W-1:0]   tmr_val;
    logic               accept, capture, step_lane, finish;
    logic               in_byte;
    logic [LANE_W-1:0]  wr_byte;

    logic unused_inputs;
    assign unused_inputs = ^{req_addr, cfg_timing[31:30], cfg_timing[1:0]};

    assign cfg_now = decode_timing(cfg_timing);

    always_comb begin
        phase_d   = phase_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        step_lane = 1'b0;
        finish    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!nand_en) begin
                        phase_d = PH_DONE;
                    end else if (hist_v_q && (hist_wr_q != req_write)) begin
                        phase_d  = PH_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = phase_len(cfg_now, PH_TURN, req_write);
                    end else begin
                        phase_d  = PH_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = phase_len(cfg_now, PH_SETUP, req_write);
                    end
                end
            end
            PH_TURN: begin
                if (tmr_expired) begin
                    phase_d  = PH_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(tim_q, PH_SETUP, wr_q);
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    phase_d  = PH_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(tim_q, PH_STROBE, wr_q);
                end
            end
            PH_STROBE: begin
                if (tmr_expired) begin
                    capture  = !wr_q;
                    phase_d  = PH_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(tim_q, PH_HOLD, wr_q);
                end
            end
            PH_HOLD: begin
                if (tmr_expired) begin
                    if (idx_q == last_q) begin
                        phase_d = PH_DONE;
                        finish  = 1'b1;
                    end else begin
                        step_lane = 1'b1;
                        phase_d   = PH_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = phase_len(tim_q, PH_SETUP, wr_q);
                    end
                end
            end
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            tim_q     <= '0;
            wr_q      <= 1'b0;
            ale_q     <= 1'b0;
            cle_q     <= 1'b0;
            chip2_q   <= 1'b0;
            wdata_q   <= '0;
            idx_q     <= '0;
            last_q    <= '0;
            hist_v_q  <= 1'b0;
            hist_wr_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                tim_q   <= cfg_now;
                wr_q    <= req_write;
                cle_q   <= req_addr[CLE_BIT];
                ale_q   <= req_addr[ALE_BIT] & ~req_addr[CLE_BIT];
                chip2_q <= req_addr[CHIP2_BIT];
                wdata_q <= req_wdata;
                idx_q   <= '0;
                last_q  <= last_lane(req_size);
            end else if (step_lane) begin
                idx_q <= idx_q + 1'b1;
            end
            if (finish) begin
                hist_v_q  <= 1'b1;
                hist_wr_q <= wr_q;
            end
        end
    end

    nand_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nand_byte_lanes #(.LANES(LANES), .LANE_W(LANE_W), .LANE_IW(LANE_IW)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .capture  (capture),
        .lane_idx (idx_q),
        .dq_in    (nand_dq_i),
        .wdata    (wdata_q),
        .wr_byte  (wr_byte),
        .rdata    (req_rdata)
    );

    nand_ready_sync #(.STAGES(2)) u_rdy (
        .clk      (clk),
        .rst      (rst),
        .async_in (wait_in),
        .sync_out (ready)
    );

    assign in_byte    = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
    assign nand_ce_n  = !in_byte ? 2'b11 : (chip2_q ? 2'b01 : 2'b10);
    assign nand_we_n  = !((phase_q == PH_STROBE) && wr_q);
    assign nand_re_n  = !((phase_q == PH_STROBE) && !wr_q);
    assign nand_cle   = in_byte && cle_q;
    assign nand_ale   = in_byte && ale_q;
    assign nand_dq_oe = in_byte && wr_q;
    assign nand_dq_o  = nand_dq_oe ? wr_byte : '0;
    assign req_ack    = (phase_q == PH_DONE);
endmodule

// File: rtl/nand_async_ctrl_chk.sv
module nand_async_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wait_in,
    input logic       ready,
    input logic [1:0] ce_n,
    input logic       we_n,
    input logic       re_n,
    input logic       ale,
    input logic       cle,
    input logic       dq_oe,
    input logic       ack
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    // R1
    ale_cle_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ale && cle));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));

    // R4
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> (ce_n != 2'b11));

    // R4
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(we_n) || $fell(re_n)) |-> ($past(ce_n) != 2'b11));

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);

    // R5
    ack_ce_idle_chk: assert property (@(posedge clk) disable iff (rst) ack |-> (ce_n == 2'b11));

    // R8
    one_chip_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~ce_n));

    // R11
    drive_not_reading_chk: assert property (@(posedge clk) disable iff (rst) dq_oe |-> re_n);

    // R10
    ready_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (ready == $past(wait_in, 2)));
endmodule

bind nand_async_ctrl nand_async_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wait_in (wait_in),
    .ready   (ready),
    .ce_n    (nand_ce_n),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .ale     (nand_ale),
    .cle     (nand_cle),
    .dq_oe   (nand_dq_oe),
    .ack     (req_ack)
);

// File: tb/nand_async_ctrl_tb.sv
module nand_async_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nand_en = 1'b1;
    logic [31:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ack;
    logic [31:0] req_rdata;
    logic        wait_in = 1'b1;
    logic        ready;
    logic [1:0]  nand_ce_n;
    logic        nand_we_n, nand_re_n, nand_ale, nand_cle, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;

    always #5 clk = ~clk;

    nand_async_ctrl u_dut (
        .clk(clk), .rst(rst), .nand_en(nand_en), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .wait_in(wait_in), .ready(ready),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
    );

    typedef struct packed {
        logic [1:0] ce;
        logic       we;
        logic       re;
        logic       ale;
        logic       cle;
        logic       oe;
        logic [7:0] dq;
        logic       ack;
    } vec_t;

    vec_t        exp_q[$];
    logic        wq[$];
    int          n_checks = 0;
    int          n_errs = 0;
    int          cycles = 0;
    int          ws, wst, wh, rs, rstb, rhd, ta;
    logic        hv = 1'b0, hw = 1'b0;
    logic [31:0] rd_bytes = '0;
    logic [31:0] exp_rdata = '0;
    logic        done = 1'b0;
    int          k = 0;
    logic        prev_re = 1'b1;

    function automatic vec_t idle_vec();
        vec_t v;
        v.ce = 2'b11; v.we = 1'b1; v.re = 1'b1; v.ale = 1'b0; v.cle = 1'b0;
        v.oe = 1'b0; v.dq = 8'h00; v.ack = 1'b0;
        return v;
    endfunction

    // R3: field layout of the timing word
    task automatic set_cfg(input int a, input int b, input int c, input int d,
                           input int e, input int f, input int g);
        ws = a; wst = b; wh = c; rs = d; rstb = e; rhd = f; ta = g;
        cfg_timing = {2'b00, 4'(a), 6'(b), 3'(c), 4'(d), 6'(e), 3'(f), 2'(g), 2'b00};
    endtask

    task automatic push_access(input logic wr, input logic [1:0] sz,
                               input logic [15:0] a, input logic [31:0] wd);
        vec_t v;
        int nb, s, st, h;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp_rdata = '0;
        if (!nand_en) begin
            v = idle_vec(); v.ack = 1'b1; exp_q.push_back(v);
        end else begin
            s  = wr ? ws : rs;
            st = wr ? wst : rstb;
            h  = wr ? wh : rhd;
            if (hv && hw != wr) repeat (ta + 1) exp_q.push_back(idle_vec());
            for (int b = 0; b < nb; b++) begin
                v = idle_vec();
                v.ce  = a[12] ? 2'b01 : 2'b10;
                v.cle = a[4];
                v.ale = a[3] & ~a[4];
                v.oe  = wr;
                v.dq  = wr ? wd[8*b +: 8] : 8'h00;
                repeat (s + 1) exp_q.push_back(v);
                v.we = ~wr; v.re = wr;
                repeat (st + 1) exp_q.push_back(v);
                v.we = 1'b1; v.re = 1'b1;
                repeat (h + 1) exp_q.push_back(v);
                if (!wr) exp_rdata[8*b +: 8] = rd_bytes[8*b +: 8];
            end
            v = idle_vec(); v.ack = 1'b1; exp_q.push_back(v);
            hv = 1'b1; hw = wr;
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                          input logic [31:0] wd, input logic [31:0] rb);
        @(negedge clk); #1;
        rd_bytes  = rb;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        push_access(wr, sz, a, wd);
        @(negedge clk); #1;
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cycles, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (rst) wq.delete();
        else begin
            wq.push_back(wait_in);
            if (wq.size() > 4) void'(wq.pop_front());
        end
    end

    always @(negedge clk) begin
        vec_t e;
        logic exp_rdy;
        cycles++;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_vec();
        exp_rdy = (wq.size() >= 2) ? wq[wq.size()-2] : 1'b0;
        chk(nand_ce_n == e.ce, "R5/R8", "ce_n", 32'(nand_ce_n), 32'(e.ce));
        chk(nand_we_n == e.we, "R4", "we_n", 32'(nand_we_n), 32'(e.we));
        chk(nand_re_n == e.re, "R4", "re_n", 32'(nand_re_n), 32'(e.re));
        chk(nand_cle == e.cle, "R1", "cle", 32'(nand_cle), 32'(e.cle));
        chk(nand_ale == e.ale, "R1", "ale", 32'(nand_ale), 32'(e.ale));
        chk(nand_dq_oe == e.oe, "R11", "dq_oe", 32'(nand_dq_oe), 32'(e.oe));
        chk(nand_dq_o == e.dq, "R11/R2", "dq_o", 32'(nand_dq_o), 32'(e.dq));
        chk(req_ack == e.ack, "R5", "ack", 32'(req_ack), 32'(e.ack));
        chk(ready == exp_rdy, "R10", "ready", 32'(ready), 32'(exp_rdy));
        if (e.ack) chk(req_rdata == exp_rdata, "R7/R9", "rdata", req_rdata, exp_rdata);
        // device model: advance read lane when the read strobe rises
        if (req_valid) k = 0;
        else if (!prev_re && nand_re_n) k = k + 1;
        prev_re   = nand_re_n;
        nand_dq_i = rd_bytes[8*(k & 3) +: 8];
        if (cycles > 150000) begin
            n_errs++;
            $display("FAIL R5 watchdog: actual cycles %0d expected below %0d", cycles, 150000);
            done = 1'b1;
        end
        if (done) begin
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        set_cfg(1, 2, 1, 0, 3, 0, 2);
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        repeat (4) @(negedge clk);
        // R6: first read after reset has no turnaround; R7 single lane
        access(1'b0, 2'd0, 16'h0000, 32'h0, 32'h0000_00A5);
        // R1: command byte, turnaround since direction changes (R6)
        access(1'b1, 2'd0, 16'h0010, 32'h0000_0070, 32'h0);
        // R1: address byte
        access(1'b1, 2'd0, 16'h0008, 32'h0000_0012, 32'h0);
        // R1: both bits set, CLE only
        access(1'b1, 2'd0, 16'h0018, 32'h0000_00FF, 32'h0);
        // R2: word write, lane order; same direction, no gap
        access(1'b1, 2'd2, 16'h0000, 32'hDEAD_BEEF, 32'h0);
        // R2: low address bits ignored, size 3 behaves as a word
        access(1'b1, 2'd3, 16'h0003, 32'h1234_5678, 32'h0);
        // R2: half word write
        access(1'b1, 2'd1, 16'h0002, 32'hAAAA_C33C, 32'h0);
        // R7: word and half reads, lanes 2 and 3 zero for the half
        access(1'b0, 2'd2, 16'h0000, 32'h0, 32'h8765_4321);
        access(1'b0, 2'd1, 16'h0001, 32'h0, 32'hFFFF_9ABC);
        // R8: second chip
        access(1'b1, 2'd1, 16'h1010, 32'h0000_5A5A, 32'h0);
        access(1'b0, 2'd0, 16'h1000, 32'h0, 32'h0000_0066);
        // R3: other field values, including maxima
        set_cfg(15, 0, 7, 2, 63, 5, 3);
        access(1'b1, 2'd1, 16'h0000, 32'h0000_0F0E, 32'h0);
        access(1'b0, 2'd0, 16'h0000, 32'h0, 32'h0000_003C);
        set_cfg(0, 0, 0, 0, 0, 0, 0);
        access(1'b1, 2'd2, 16'h0004, 32'h0102_0304, 32'h0);
        access(1'b0, 2'd2, 16'h0000, 32'h0, 32'hCAFE_F00D);
        // R9: disabled read is acked with no bus activity and no history change
        access(1'b1, 2'd0, 16'h0000, 32'h0000_0011, 32'h0);
        #1 nand_en = 1'b0;
        access(1'b0, 2'd2, 16'h0010, 32'h0, 32'h1111_1111);
        #1 nand_en = 1'b1;
        access(1'b1, 2'd0, 16'h0000, 32'h0000_0022, 32'h0);
        // R10: ready follows the shared busy line
        @(negedge clk); #1 wait_in = 1'b0;
        repeat (4) @(negedge clk);
        #1 wait_in = 1'b1;
        @(negedge clk); #1 wait_in = 1'b0;
        @(negedge clk); #1 wait_in = 1'b1;
        repeat (4) @(negedge clk);
        #1 done = 1'b1;
    end
endmodule